// File: doc/BRIEF.md
# Calibrated One-Second Divider

This block turns a stream of oscillator enable pulses, nominally 32768 per second, into a one-clock pulse once per second. The count is split at a divide-by-256 prescaler, and rate calibration acts on that prescaler. A signed calibration value in a control byte selects how many minutes of a repeating 64-minute cycle carry one altered second. A positive setting shortens that second by one full prescaler period. A negative setting stretches it by holding the prescaler for half a period. A separate minute-boundary pulse from the surrounding timekeeping logic advances the position in the 64-minute cycle.

The same control byte drives an open-drain test pin. With the test bit set, the pin toggles at 512 Hz from a counter that calibration does not touch, so the raw oscillator rate can be measured on the pin. With the test bit clear, the pin holds the programmed output level. The control byte is loaded through a write strobe and comes out of reset with the pin released and calibration off.

Top module: `cal_sec_divider`

## Requirements
- R1: After reset the control byte is 0x80: the pin is released (pin_low_en = 0) and does not toggle, calibration is off, the cycle position is 0 and no altered second is pending.
- R2: A control write takes effect one clock later. Field layout: bits 4:0 are the magnitude N (0 to 31), bit 5 is the direction (1 = shorten, 0 = stretch), bit 6 selects the 512 Hz test output, and bit 7 is the static output level.
- R3: An unaltered second spans OSC_HZ oscillator enables. sec_tick is high for exactly one clock, in the clock after the enable that completes the second.
- R4: Each minute pulse advances the cycle position modulo 64. If the new position is below 2N, with N and the direction sampled at that pulse, the next second to begin is altered. At most one second per minute pulse is altered.
- R5: A shortened second spans OSC_HZ - 256 oscillator enables.
- R6: A stretched second spans OSC_HZ + 128 oscillator enables, with the 128 held enables at its start.
- R7: Changing N between minute pulses leaves the second lengths unchanged until the next minute pulse.
- R8: With N = 31, position 63 is outside the window and no second is altered. After the wrap to position 0, a second is altered.
- R9: With the test bit set, the pin changes state every OSC_HZ/1024 oscillator enables, also while a calibrated second is shortened or stretched.
- R10: With the test bit clear, pin_low_en is the inverse of the output level bit.
- R11: Clocks without an oscillator enable advance neither the second count nor the test toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| ctrl_we | input | 1 | Load strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte value to load |
| minute_pulse | input | 1 | One-clock pulse at each minute boundary |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| pin_low_en | output | 1 | Open-drain pull-down enable for the test/output pin |

## Verification
sec_tick is registered, so it rises one clock after the enable that completes a second. Second lengths are therefore measured from one tick to the next on falling edges, which cancels that fixed delay. A control write shows at the pin on the falling edge right after the write clock, and the pin is sampled there. A minute pulse changes nothing in the second that is running. Each scenario therefore pulses just after a tick and expects the altered length only in the following tick-to-tick interval. Test-pin intervals are measured between observed pin transitions, and the first transition in each window is skipped because it may be partial.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef struct packed {
    logic       out_lvl;
    logic       ftest;
    logic       speed_up;
    logic [4:0] mag;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{out_lvl: 1'b1, ftest: 1'b0, speed_up: 1'b0, mag: 5'd0};

  // Position lies inside the altered window of the cycle (first 2N minutes).
  function automatic logic in_window(int unsigned pos, logic [4:0] mag);
    return pos < (32'(mag) << 1);
  endfunction

  // Final value of the upper stage; a shortened second drops one prescaler period.
  function automatic int unsigned last_hi(int unsigned hi_mod, logic shorten);
    return shorten ? hi_mod - 2 : hi_mod - 1;
  endfunction

endpackage

// File: rtl/csd_cycle_seq.sv
module csd_cycle_seq
  import csd_pkg::*;
#(
  parameter int unsigned CYC_MIN = 64,
  parameter int unsigned POS_W   = $clog2(CYC_MIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             minute_pulse,
  input  logic [4:0]       mag,
  input  logic             speed_up,
  input  logic             consume,
  output logic [POS_W-1:0] cyc_pos,
  output logic             adj_pending,
  output logic             pend_pos
);

  logic [POS_W-1:0] pos_nxt;
  logic             arm;

  always_comb begin
    pos_nxt = (cyc_pos == POS_W'(CYC_MIN - 1)) ? '0 : cyc_pos + 1'b1;
    arm     = minute_pulse && in_window(32'(pos_nxt), mag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_pos     <= '0;
      adj_pending <= 1'b0;
      pend_pos    <= 1'b0;
    end else begin
      if (minute_pulse) cyc_pos <= pos_nxt;
      if (arm) begin
        adj_pending <= 1'b1;
        pend_pos    <= speed_up;
      end else if (consume) begin
        adj_pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/csd_sec_count.sv
module csd_sec_count
  import csd_pkg::*;
#(
  parameter int unsigned OSC_HZ = 32768,
  parameter int unsigned STAGE  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic adj_pending,
  input  logic pend_pos,
  output logic sec_end,
  output logic sec_tick,
  output logic adj_active,
  output logic adj_pos,
  output logic blanking
);

  localparam int unsigned HI_MOD = OSC_HZ / STAGE;
  localparam int unsigned BLANK  = STAGE / 2;
  localparam int unsigned PW     = $clog2(STAGE);
  localparam int unsigned HW     = $clog2(HI_MOD);
  localparam int unsigned BW     = $clog2(BLANK);

  logic [PW-1:0] pre;
  logic [HW-1:0] hi;
  logic [BW-1:0] blk;
  logic          blk_done;
  logic          pre_end;
  logic          hi_end;

  always_comb begin
    pre_end  = (pre == PW'(STAGE - 1));
    hi_end   = (hi == HW'(last_hi(HI_MOD, adj_active && adj_pos)));
    blanking = adj_active && !adj_pos && !blk_done;
    sec_end  = osc_en && !blanking && pre_end && hi_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre        <= '0;
      hi         <= '0;
      blk        <= '0;
      blk_done   <= 1'b0;
      adj_active <= 1'b0;
      adj_pos    <= 1'b0;
      sec_tick   <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      if (osc_en) begin
        if (blanking) begin
          if (blk == BW'(BLANK - 1)) begin
            blk      <= '0;
            blk_done <= 1'b1;
          end else begin
            blk <= blk + 1'b1;
          end
        end else begin
          pre <= pre_end ? '0 : pre + 1'b1;
          if (pre_end) hi <= hi_end ? '0 : hi + 1'b1;
        end
      end
      if (sec_end) begin
        adj_active <= adj_pending;
        adj_pos    <= pend_pos;
        blk_done   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/csd_test_pin.sv
module csd_test_pin #(
  parameter int unsigned OSC_HZ  = 32768,
  parameter int unsigned TEST_HZ = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic ftest,
  input  logic out_lvl,
  output logic tog,
  output logic pin_low_en
);

  localparam int unsigned HALF = OSC_HZ / (2 * TEST_HZ);
  localparam int unsigned TW   = $clog2(HALF);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b1;
    end else if (osc_en) begin
      if (cnt == TW'(HALF - 1)) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pin_low_en = ftest ? ~tog : ~out_lvl;

endmodule

// File: rtl/cal_sec_divider.sv
module cal_sec_divider
  import csd_pkg::*;
#(
  parameter int unsigned OSC_HZ  = 32768,
  parameter int unsigned STAGE   = 256,
  parameter int unsigned TEST_HZ = 512,
  parameter int unsigned CYC_MIN = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       minute_pulse,
  output logic       sec_tick,
  output logic       pin_low_en
);

  localparam int unsigned POS_W = $clog2(CYC_MIN);

  ctrl_t            ctrl_q;
  logic [POS_W-1:0] cyc_pos;
  logic             adj_pending;
  logic             pend_pos;
  logic             sec_end;
  logic             adj_active;
  logic             adj_pos;
  logic             blanking;
  logic             tog;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
  end

  csd_cycle_seq #(.CYC_MIN(CYC_MIN), .POS_W(POS_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .minute_pulse(minute_pulse),
    .mag         (ctrl_q.mag),
    .speed_up    (ctrl_q.speed_up),
    .consume     (sec_end),
    .cyc_pos     (cyc_pos),
    .adj_pending (adj_pending),
    .pend_pos    (pend_pos)
  );

  csd_sec_count #(.OSC_HZ(OSC_HZ), .STAGE(STAGE)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .adj_pending(adj_pending),
    .pend_pos   (pend_pos),
    .sec_end    (sec_end),
    .sec_tick   (sec_tick),
    .adj_active (adj_active),
    .adj_pos    (adj_pos),
    .blanking   (blanking)
  );

  csd_test_pin #(.OSC_HZ(OSC_HZ), .TEST_HZ(TEST_HZ)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .ftest     (ctrl_q.ftest),
    .out_lvl   (ctrl_q.out_lvl),
    .tog       (tog),
    .pin_low_en(pin_low_en)
  );

endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int unsigned POS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             ctrl_we,
  input logic [7:0]       ctrl_q,
  input logic             minute_pulse,
  input logic             sec_tick,
  input logic             sec_end,
  input logic             adj_pending,
  input logic             adj_active,
  input logic             adj_pos,
  input logic             blanking,
  input logic             tog,
  input logic [POS_W-1:0] cyc_pos
);

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));

  p_tick_after_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_en));

  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  p_pos_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !minute_pulse |=> $stable(cyc_pos));

  p_pend_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_end && !minute_pulse) |=> !adj_pending);

  p_blank_neg_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |-> (adj_active && !adj_pos));

  p_no_end_in_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |=> !sec_tick);

  p_tog_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(tog));

endmodule

bind cal_sec_divider csd_checker #(.POS_W(POS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .osc_en      (osc_en),
  .ctrl_we     (ctrl_we),
  .ctrl_q      (ctrl_q),
  .minute_pulse(minute_pulse),
  .sec_tick    (sec_tick),
  .sec_end     (sec_end),
  .adj_pending (adj_pending),
  .adj_active  (adj_active),
  .adj_pos     (adj_pos),
  .blanking    (blanking),
  .tog         (tog),
  .cyc_pos     (cyc_pos)
);

// File: tb/cal_sec_divider_bench.sv
module cal_sec_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OSC_HZ     = 4096;
  localparam int NORM       = OSC_HZ;
  localparam int SHORT_LEN  = OSC_HZ - 256;
  localparam int LONG_LEN   = OSC_HZ + 128;
  localparam int HALF       = OSC_HZ / 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       minute_pulse = 1'b0;
  logic       sec_tick;
  logic       pin_low_en;
  logic       gate_mode = 1'b0;

  int checks = 0;
  int fails = 0;
  int cnt = 0;
  int last_gap = 0;
  event gap_ev;

  cal_sec_divider #(.OSC_HZ(OSC_HZ)) u_cal_sec_divider (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .minute_pulse(minute_pulse),
    .sec_tick    (sec_tick),
    .pin_low_en  (pin_low_en)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (gate_mode) osc_en <= ~osc_en;
    else           osc_en <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) cnt = 0;
    else begin
      cnt++;
      if (sec_tick) begin
        last_gap = cnt;
        cnt = 0;
        ->gap_ev;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_gap(output int g);
    @(gap_ev);
    g = last_gap;
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_wdata = v;
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic pulse_min();
    minute_pulse = 1'b1;
    @(negedge clk);
    minute_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    int moves = 0;
    logic prev;
    chk("R1 pin released", int'(pin_low_en), 0);
    chk("R1 no tick", int'(sec_tick), 0);
    prev = pin_low_en;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pin_low_en != prev) moves++;
      prev = pin_low_en;
    end
    chk("R1 pin not toggling", moves, 0);
  endtask

  task automatic t_normal();
    int g;
    wait_gap(g);
    wait_gap(g); chk("R3 plain second", g, NORM);
    wait_gap(g); chk("R3 plain second again", g, NORM);
  endtask

  task automatic t_positive();
    int g;
    wr(8'hA1);                       // N=1, shorten; R2
    pulse_min();                     // position 1 < 2
    wait_gap(g); chk("R4 running second untouched", g, NORM);
    wait_gap(g); chk("R5 shortened second", g, SHORT_LEN);
    wait_gap(g); chk("R4 one second per minute", g, NORM);
  endtask

  task automatic t_negative();
    int g;
    wr(8'h82);                       // N=2, stretch
    pulse_min();                     // position 2 < 4
    wait_gap(g); chk("R4 running second untouched", g, NORM);
    wait_gap(g); chk("R6 stretched second", g, LONG_LEN);
    wait_gap(g); chk("R6 back to plain", g, NORM);
  endtask

  task automatic t_late_change();
    int g;
    wr(8'h80);                       // N=0
    pulse_min();                     // position 3, empty window
    wait_gap(g); chk("R4 N=0 no change", g, NORM);
    wait_gap(g); chk("R4 N=0 no change", g, NORM);
    wr(8'hBF);                       // N=31 shorten, no minute pulse
    wait_gap(g); chk("R7 mid-minute write ignored", g, NORM);
    wait_gap(g); chk("R7 mid-minute write ignored", g, NORM);
    pulse_min();                     // position 4
    wait_gap(g); chk("R7 running second untouched", g, NORM);
    wait_gap(g); chk("R7 applied after pulse", g, SHORT_LEN);
  endtask

  task automatic t_wrap();
    int g;
    wr(8'h80);
    for (int i = 0; i < 58; i++) pulse_min();   // position 62
    wr(8'hBF);
    pulse_min();                                 // position 63
    wait_gap(g); chk("R8 position 63 plain", g, NORM);
    wait_gap(g); chk("R8 position 63 plain", g, NORM);
    pulse_min();                                 // wraps to 0
    wait_gap(g); chk("R8 running second untouched", g, NORM);
    wait_gap(g); chk("R8 position 0 altered", g, SHORT_LEN);
  endtask

  task automatic t_out_level();
    wr(8'h00);
    chk("R10 level 0 pulls low", int'(pin_low_en), 1);
    wr(8'h80);
    chk("R10 level 1 releases", int'(pin_low_en), 0);
  endtask

  task automatic t_ftest();
    int g;
    int bad = 0;
    int n = 0;
    int last = -1;
    logic prev;
    wait_gap(g);
    wr(8'h41);                       // test on, N=1 stretch
    pulse_min();                     // position 1 < 2
    wait_gap(g); chk("R4 running second untouched", g, NORM);
    prev = pin_low_en;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pin_low_en != prev) begin
        if (last >= 0 && (i - last) != HALF) bad++;
        last = i;
        n++;
        prev = pin_low_en;
      end
    end
    chk("R9 toggle interval during stretch", bad, 0);
    chk("R9 toggle count", int'(n >= 149 && n <= 151), 1);
    wait_gap(g); chk("R6 stretched with test on", g, LONG_LEN);
  endtask

  task automatic t_gated();
    int g;
    wr(8'h80);
    gate_mode = 1'b1;
    wait_gap(g);
    wait_gap(g); chk("R11 half-rate enable", g, 2 * NORM);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_positive();
    t_negative();
    t_late_change();
    t_wrap();
    t_out_level();
    t_ftest();
    t_gated();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule